// File: doc/BRIEF.md
# Store Writeback Unit with Retry

This block holds committed stores in a circular queue and sends them to a data-cache port, one store per cycle and oldest first. A store enters through the enqueue port. When it reaches the head, it is offered on a valid/accept request channel. If the cache refuses a request, the unit copies that request into a single holding register and becomes store-blocked. It drains nothing more until a one-cycle retry pulse lets it offer the held request again and the cache takes it.

Store-conditionals are resolved inside the block against a link flag. A load with the locked attribute sets the flag and records its address, and a separate clear input drops the flag. An uncacheable store-conditional reports code 2 and is sent. A cacheable one reports code 1 and is sent when the flag is set. When the flag is clear, it reports code 0 and retires at once, with no cache request. The block also remembers one stalled load: the sequence number of the store that load waits on, and the load's index. When that store is handed to the cache, the block clears the stall and pulses a replay carrying the load index.

Top module: `stq_wb_unit`

## Requirements
- R1: After reset the queue is empty, not full, not blocked and the link flag is clear. The queue holds DEPTH entries, `sq_full` is high exactly when DEPTH stores are held, and an enqueue offered while full is dropped without effect.
- R2: When not blocked and the queue is not empty, the head store is offered on `req_valid` with its address, data and locked flag in the same cycle. A handshake happens in a cycle where `req_valid` and `req_accept` are both high. After a handshake on an ordinary store, `cmpl_valid` pulses for one cycle on the next clock with that store's queue index, and the store leaves the queue.
- R3: When `req_valid` is high and `req_accept` is low while not blocked, `wb_blocked` rises on the next clock. While blocked, `req_valid` stays low except in cycles where `req_retry` is high, and no other store is offered.
- R4: A retry while blocked offers the held request again in that same cycle. If it is accepted, the unit unblocks and the store is retired as in R2. If it is refused, the unit stays blocked with the same held request.
- R5: A retry while not blocked causes no request; with an empty queue `req_valid` stays low.
- R6: A locked store marked uncacheable is sent, and on its handshake `sc_valid` pulses on the next clock with code 2 and its index.
- R7: A cacheable locked store offered while the link flag is set is sent with code 1, which is fixed at its first offer even if the flag clears while it is blocked. It reports `sc_valid` on its handshake and raises no `cmpl_valid`.
- R8: A cacheable locked store that reaches the head while the link flag is clear is never offered. On the next clock `sc_valid` pulses with code 0 and `cmpl_valid` pulses with its index, and the queue advances.
- R9: When a stall is recorded and a store whose sequence number equals the recorded one completes a handshake, `replay_valid` pulses on the next clock with the recorded load index and the stall is cleared. A store with a different sequence number triggers no replay.
- R10: `ll_valid` sets the link flag and records `ll_addr` on the next clock. `link_clear` clears the flag, and `ll_valid` wins when both are high.
- R11: Queue indices run from 0 to DEPTH-1 and wrap back to 0; reported indices follow enqueue order modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue a committed store |
| enq_addr | input | ADDR_W | Store address |
| enq_data | input | DATA_W | Store data |
| enq_seq | input | SEQ_W | Store sequence number |
| enq_locked | input | 1 | Store is a store-conditional |
| enq_uncached | input | 1 | Store targets uncacheable space |
| sq_full | output | 1 | Queue holds DEPTH entries |
| sq_empty | output | 1 | Queue holds no entry |
| req_valid | output | 1 | Cache request offered |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |
| req_cond | output | 1 | Request is a store-conditional |
| req_accept | input | 1 | Cache takes the request this cycle |
| req_retry | input | 1 | One-cycle pulse: cache can take a refused request |
| ll_valid | input | 1 | Locked load executes |
| ll_addr | input | ADDR_W | Address of the locked load |
| link_clear | input | 1 | Drop the link flag |
| link_flag | output | 1 | Current link flag |
| link_addr | output | ADDR_W | Recorded link address |
| stall_set | input | 1 | Record a stalled load |
| stall_seq | input | SEQ_W | Sequence number of the store the load waits on |
| stall_ld_idx | input | LDX_W | Index of the stalled load |
| replay_valid | output | 1 | Replay the stalled load |
| replay_ld_idx | output | LDX_W | Index of the load to replay |
| cmpl_valid | output | 1 | Store marked completed |
| cmpl_idx | output | $clog2(DEPTH) | Queue index of the completed store |
| sc_valid | output | 1 | Store-conditional result available |
| sc_idx | output | $clog2(DEPTH) | Queue index of that store |
| sc_code | output | 2 | 0 failed, 1 succeeded, 2 uncacheable |
| wb_blocked | output | 1 | A refused request is being held |

## Verification
The assertions assume a cache that treats `req_accept` as meaningful only while `req_valid` is high, and that sends `req_retry` as an isolated pulse. They also assume the producer never relies on an enqueue being taken while `sq_full` is high. The stimulus makes `req_accept` and `req_retry` independent, so accepts also arrive in cycles with no request and retries also arrive when nothing is held; both must then be ignored. It drives enqueues past the full point on purpose. Sequence numbers start at 1, so a zeroed stall record never matches a real store.

// File: rtl/stq_wb_pkg.sv
package stq_wb_pkg;

    // Store-conditional outcome codes reported on sc_code.
    typedef enum logic [1:0] {
        SC_FAIL     = 2'd0,
        SC_OK       = 2'd1,
        SC_UNCACHED = 2'd2
    } sc_code_e;

endpackage

// File: rtl/stq_ring.sv
// Circular store storage: pointers carry one extra lap bit.
module stq_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 82
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head_data,
    output logic [$clog2(DEPTH)-1:0]   head_idx,
    output logic                       full,
    output logic                       empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] head_q, head_d;
    logic [PTR_W-1:0] tail_q, tail_d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        logic [IDX_W-1:0] i;
        i = p[IDX_W-1:0];
        if (i == IDX_W'(DEPTH - 1))
            return {~p[PTR_W-1], {IDX_W{1'b0}}};
        return {p[PTR_W-1], i + IDX_W'(1)};
    endfunction

    assign empty     = (head_q == tail_q);
    assign full      = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) &&
                       (head_q[PTR_W-1] != tail_q[PTR_W-1]);
    assign head_idx  = head_q[IDX_W-1:0];
    assign head_data = mem[head_idx];

    always_comb begin
        head_d = head_q;
        tail_d = tail_q;
        if (pop && !empty) head_d = bump(head_q);
        if (push && !full) tail_d = bump(tail_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_d;
            tail_q <= tail_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[tail_q[IDX_W-1:0]] <= push_data;
    end

endmodule

// File: rtl/stq_link.sv
// Link flag and address set by locked loads.
module stq_link #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr,
    output logic              flag,
    output logic [ADDR_W-1:0] addr
);
    logic              flag_q, flag_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    always_comb begin
        flag_d = flag_q;
        addr_d = addr_q;
        if (clr) flag_d = 1'b0;
        if (set) begin
            flag_d = 1'b1;
            addr_d = set_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            addr_q <= '0;
        end else begin
            flag_q <= flag_d;
            addr_q <= addr_d;
        end
    end

    assign flag = flag_q;
    assign addr = addr_q;

endmodule

// File: rtl/stq_wb_unit.sv
module stq_wb_unit
    import stq_wb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SEQ_W  = 16,
    parameter int LDX_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enq_valid,
    input  logic [ADDR_W-1:0]        enq_addr,
    input  logic [DATA_W-1:0]        enq_data,
    input  logic [SEQ_W-1:0]         enq_seq,
    input  logic                     enq_locked,
    input  logic                     enq_uncached,
    output logic                     sq_full,
    output logic                     sq_empty,
    output logic                     req_valid,
    output logic [ADDR_W-1:0]        req_addr,
    output logic [DATA_W-1:0]        req_data,
    output logic                     req_cond,
    input  logic                     req_accept,
    input  logic                     req_retry,
    input  logic                     ll_valid,
    input  logic [ADDR_W-1:0]        ll_addr,
    input  logic                     link_clear,
    output logic                     link_flag,
    output logic [ADDR_W-1:0]        link_addr,
    input  logic                     stall_set,
    input  logic [SEQ_W-1:0]         stall_seq,
    input  logic [LDX_W-1:0]         stall_ld_idx,
    output logic                     replay_valid,
    output logic [LDX_W-1:0]         replay_ld_idx,
    output logic                     cmpl_valid,
    output logic [$clog2(DEPTH)-1:0] cmpl_idx,
    output logic                     sc_valid,
    output logic [$clog2(DEPTH)-1:0] sc_idx,
    output logic [1:0]               sc_code,
    output logic                     wb_blocked
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int ENT_W = ADDR_W + DATA_W + SEQ_W + 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SEQ_W-1:0]  seq;
        logic              locked;
        logic              uncached;
    } entry_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SEQ_W-1:0]  seq;
        logic [IDX_W-1:0]  idx;
        logic              locked;
        sc_code_e          code;
    } pkt_t;

    typedef struct packed {
        logic             blocked;
        pkt_t             hold;
        logic             stalled;
        logic [SEQ_W-1:0] stall_seq;
        logic [LDX_W-1:0] stall_ld;
        logic             cmpl_v;
        logic [IDX_W-1:0] cmpl_idx;
        logic             sc_v;
        logic [IDX_W-1:0] sc_idx;
        sc_code_e         sc_code;
        logic             rp_v;
        logic [LDX_W-1:0] rp_idx;
    } state_t;

    state_t            st_q, st_d;
    entry_t            enq_ent, head;
    logic [ENT_W-1:0]  head_bits;
    logic [IDX_W-1:0]  head_idx;
    logic              pop;
    logic              link_flag_w;
    pkt_t              fresh, send_pkt;
    logic              sent_ok;
    logic [ADDR_W-1:0] hold_addr_w;

    assign enq_ent = '{addr: enq_addr, data: enq_data, seq: enq_seq,
                       locked: enq_locked, uncached: enq_uncached};

    stq_ring #(.DEPTH(DEPTH), .W(ENT_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (enq_valid),
        .push_data (enq_ent),
        .pop       (pop),
        .head_data (head_bits),
        .head_idx  (head_idx),
        .full      (sq_full),
        .empty     (sq_empty)
    );

    stq_link #(.ADDR_W(ADDR_W)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (ll_valid),
        .set_addr (ll_addr),
        .clr      (link_clear),
        .flag     (link_flag_w),
        .addr     (link_addr)
    );

    assign head      = entry_t'(head_bits);
    assign link_flag = link_flag_w;

    always_comb begin
        st_d        = st_q;
        st_d.cmpl_v = 1'b0;
        st_d.sc_v   = 1'b0;
        st_d.rp_v   = 1'b0;
        pop         = 1'b0;
        sent_ok     = 1'b0;

        fresh.addr   = head.addr;
        fresh.data   = head.data;
        fresh.seq    = head.seq;
        fresh.idx    = head_idx;
        fresh.locked = head.locked;
        fresh.code   = head.uncached ? SC_UNCACHED : (link_flag_w ? SC_OK : SC_FAIL);

        send_pkt  = st_q.blocked ? st_q.hold : fresh;
        req_valid = 1'b0;
        req_addr  = send_pkt.addr;
        req_data  = send_pkt.data;
        req_cond  = send_pkt.locked;

        if (!st_q.blocked) begin
            if (!sq_empty) begin
                if (head.locked && !head.uncached && !link_flag_w) begin
                    // failed conditional retires without touching the cache
                    pop           = 1'b1;
                    st_d.cmpl_v   = 1'b1;
                    st_d.cmpl_idx = head_idx;
                    st_d.sc_v     = 1'b1;
                    st_d.sc_idx   = head_idx;
                    st_d.sc_code  = SC_FAIL;
                end else begin
                    req_valid = 1'b1;
                    if (req_accept) begin
                        sent_ok = 1'b1;
                    end else begin
                        st_d.blocked = 1'b1;
                        st_d.hold    = fresh;
                    end
                end
            end
        end else if (req_retry) begin
            req_valid = 1'b1;
            if (req_accept) begin
                sent_ok      = 1'b1;
                st_d.blocked = 1'b0;
            end
        end

        if (sent_ok) begin
            pop = 1'b1;
            if (st_q.stalled && (send_pkt.seq == st_q.stall_seq)) begin
                st_d.stalled   = 1'b0;
                st_d.stall_seq = '0;
                st_d.rp_v      = 1'b1;
                st_d.rp_idx    = st_q.stall_ld;
            end
            if (send_pkt.locked) begin
                st_d.sc_v    = 1'b1;
                st_d.sc_idx  = send_pkt.idx;
                st_d.sc_code = send_pkt.code;
            end else begin
                st_d.cmpl_v   = 1'b1;
                st_d.cmpl_idx = send_pkt.idx;
            end
        end

        if (stall_set) begin
            st_d.stalled   = 1'b1;
            st_d.stall_seq = stall_seq;
            st_d.stall_ld  = stall_ld_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign replay_valid  = st_q.rp_v;
    assign replay_ld_idx = st_q.rp_idx;
    assign cmpl_valid    = st_q.cmpl_v;
    assign cmpl_idx      = st_q.cmpl_idx;
    assign sc_valid      = st_q.sc_v;
    assign sc_idx        = st_q.sc_idx;
    assign sc_code       = st_q.sc_code;
    assign wb_blocked    = st_q.blocked;
    assign hold_addr_w   = st_q.hold.addr;

endmodule

// File: rtl/stq_wb_unit_chk.sv
module stq_wb_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_accept,
    input logic              req_retry,
    input logic              wb_blocked,
    input logic              sq_empty,
    input logic [ADDR_W-1:0] hold_addr,
    input logic              sc_valid,
    input logic [1:0]        sc_code,
    input logic              cmpl_valid
);
    p_refuse_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_blocked && req_valid && !req_accept |=> wb_blocked);

    p_stay_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_blocked && !(req_valid && req_accept) |=> wb_blocked);

    p_quiet_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_blocked && !req_retry |-> !req_valid);

    p_hold_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_blocked && $past(wb_blocked) |-> $stable(hold_addr));

    p_idle_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_blocked && sq_empty |-> !req_valid);

    p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |-> sc_code != 2'd3);

    p_sc_not_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && sc_code != 2'd0 |-> !cmpl_valid);

    p_fail_completes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && sc_code == 2'd0 |-> cmpl_valid);

endmodule

bind stq_wb_unit stq_wb_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_accept (req_accept),
    .req_retry  (req_retry),
    .wb_blocked (wb_blocked),
    .sq_empty   (sq_empty),
    .hold_addr  (hold_addr_w),
    .sc_valid   (sc_valid),
    .sc_code    (sc_code),
    .cmpl_valid (cmpl_valid)
);

// File: tb/stq_wb_unit_test.sv
module stq_wb_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int SEQ_W  = 16;
    localparam int LDX_W  = 5;
    localparam int IDX_W  = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 0, enq_locked = 0, enq_uncached = 0;
    logic [ADDR_W-1:0] enq_addr = '0, ll_addr = '0;
    logic [DATA_W-1:0] enq_data = '0;
    logic [SEQ_W-1:0]  enq_seq = '0, stall_seq = '0;
    logic req_accept = 0, req_retry = 0, ll_valid = 0, link_clear = 0, stall_set = 0;
    logic [LDX_W-1:0] stall_ld_idx = '0;
    logic sq_full, sq_empty, req_valid, req_cond, link_flag, replay_valid;
    logic cmpl_valid, sc_valid, wb_blocked;
    logic [ADDR_W-1:0] req_addr, link_addr;
    logic [DATA_W-1:0] req_data;
    logic [LDX_W-1:0] replay_ld_idx;
    logic [IDX_W-1:0] cmpl_idx, sc_idx;
    logic [1:0] sc_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    stq_wb_unit #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .SEQ_W(SEQ_W), .LDX_W(LDX_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_data(enq_data),
        .enq_seq(enq_seq), .enq_locked(enq_locked), .enq_uncached(enq_uncached),
        .sq_full(sq_full), .sq_empty(sq_empty),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_cond(req_cond), .req_accept(req_accept), .req_retry(req_retry),
        .ll_valid(ll_valid), .ll_addr(ll_addr), .link_clear(link_clear),
        .link_flag(link_flag), .link_addr(link_addr),
        .stall_set(stall_set), .stall_seq(stall_seq), .stall_ld_idx(stall_ld_idx),
        .replay_valid(replay_valid), .replay_ld_idx(replay_ld_idx),
        .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
        .sc_valid(sc_valid), .sc_idx(sc_idx), .sc_code(sc_code),
        .wb_blocked(wb_blocked)
    );

    typedef struct {
        longint a; longint d; int s; bit lk; bit uc; int idx;
    } ent_t;

    ent_t   mq[$];
    int     m_tail_idx = 0;
    bit     m_blk = 0;
    ent_t   m_hold;
    int     m_hold_code = 0;
    bit     m_link = 0;
    longint m_laddr = 0;
    bit     m_stl = 0;
    int     m_sseq = 0, m_sld = 0;
    bit     x_cmpl = 0, x_sc = 0, x_rp = 0;
    int     x_cidx = 0, x_sidx = 0, x_scode = 0, x_rpidx = 0;

    int n_checks = 0, n_fail = 0;
    string cur_req = "R1";
    int next_seq = 1;
    logic [31:0] lfsr = 32'h1234_5678;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic rnd_next();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
    endtask

    task automatic idle_inputs();
        enq_valid = 0; enq_locked = 0; enq_uncached = 0;
        req_accept = 0; req_retry = 0; ll_valid = 0; link_clear = 0; stall_set = 0;
    endtask

    task automatic set_push(input bit lk, input bit uc);
        enq_valid = 1; enq_locked = lk; enq_uncached = uc;
        enq_addr = ADDR_W'(32'h1000_0000 + next_seq * 4);
        enq_data = DATA_W'(32'hA500_0000 ^ next_seq);
        enq_seq = SEQ_W'(next_seq);
        next_seq++;
    endtask

    // One clock: compare registered and combinational outputs, advance the model.
    task automatic step();
        ent_t e;
        bit rv, fail, sent, full_pre;
        int code;
        #1;
        chk(cmpl_valid === x_cmpl, "cmpl_valid", longint'(cmpl_valid), longint'(x_cmpl));
        if (x_cmpl) chk(int'(cmpl_idx) == x_cidx, "cmpl_idx", longint'(cmpl_idx), x_cidx);
        chk(sc_valid === x_sc, "sc_valid", longint'(sc_valid), longint'(x_sc));
        if (x_sc) begin
            chk(int'(sc_idx) == x_sidx, "sc_idx", longint'(sc_idx), x_sidx);
            chk(int'(sc_code) == x_scode, "sc_code", longint'(sc_code), x_scode);
        end
        chk(replay_valid === x_rp, "replay_valid", longint'(replay_valid), longint'(x_rp));
        if (x_rp) chk(int'(replay_ld_idx) == x_rpidx, "replay_ld_idx", longint'(replay_ld_idx), x_rpidx);
        chk(link_flag === m_link, "link_flag", longint'(link_flag), longint'(m_link));
        if (m_link) chk(longint'(link_addr) == m_laddr, "link_addr", longint'(link_addr), m_laddr);
        full_pre = (mq.size() == DEPTH);
        chk(sq_full === full_pre, "sq_full", longint'(sq_full), longint'(full_pre));
        chk(sq_empty === (mq.size() == 0), "sq_empty", longint'(sq_empty), longint'(mq.size() == 0));
        chk(wb_blocked === m_blk, "wb_blocked", longint'(wb_blocked), longint'(m_blk));

        rv = 0; fail = 0; code = 0;
        if (!m_blk) begin
            if (mq.size() > 0) begin
                e = mq[0];
                if (e.lk && !e.uc && !m_link) fail = 1;
                else begin
                    rv = 1;
                    code = e.uc ? 2 : (m_link ? 1 : 0);
                end
            end
        end else if (req_retry) begin
            rv = 1; e = m_hold; code = m_hold_code;
        end
        chk(req_valid === rv, "req_valid", longint'(req_valid), longint'(rv));
        if (rv) begin
            chk(longint'(req_addr) == e.a, "req_addr", longint'(req_addr), e.a);
            chk(longint'(req_data) == e.d, "req_data", longint'(req_data), e.d);
            chk(req_cond === e.lk, "req_cond", longint'(req_cond), longint'(e.lk));
        end

        x_cmpl = 0; x_sc = 0; x_rp = 0;
        sent = rv && req_accept;
        if (fail) begin
            void'(mq.pop_front());
            x_cmpl = 1; x_cidx = e.idx; x_sc = 1; x_sidx = e.idx; x_scode = 0;
        end
        if (sent) begin
            if (m_stl && e.s == m_sseq) begin
                m_stl = 0; m_sseq = 0; x_rp = 1; x_rpidx = m_sld;
            end
            if (e.lk) begin x_sc = 1; x_sidx = e.idx; x_scode = code; end
            else begin x_cmpl = 1; x_cidx = e.idx; end
            void'(mq.pop_front());
            m_blk = 0;
        end else if (rv && !m_blk) begin
            m_blk = 1; m_hold = e; m_hold_code = code;
        end
        if (enq_valid && !full_pre) begin
            ent_t n;
            n.a = longint'(enq_addr); n.d = longint'(enq_data); n.s = int'(enq_seq);
            n.lk = enq_locked; n.uc = enq_uncached; n.idx = m_tail_idx;
            mq.push_back(n);
            m_tail_idx = (m_tail_idx == DEPTH - 1) ? 0 : m_tail_idx + 1;
        end
        if (link_clear) m_link = 0;
        if (ll_valid) begin m_link = 1; m_laddr = longint'(ll_addr); end
        if (stall_set) begin m_stl = 1; m_sseq = int'(stall_seq); m_sld = int'(stall_ld_idx); end
        @(posedge clk);
        #1;
    endtask

    task automatic run_idle(input int n);
        for (int i = 0; i < n; i++) begin idle_inputs(); step(); end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        run_idle(2);

        // R2: ordinary stores drained back to back
        cur_req = "R2";
        for (int i = 0; i < 5; i++) begin
            idle_inputs(); set_push(0, 0); req_accept = 1; step();
        end
        for (int i = 0; i < 3; i++) begin idle_inputs(); req_accept = 1; step(); end

        // R3 and R1: refusal blocks; fill past full
        cur_req = "R3";
        for (int i = 0; i < 18; i++) begin
            idle_inputs(); set_push(0, 0); if (i >= 16) cur_req = "R1"; step();
        end
        cur_req = "R3";
        for (int i = 0; i < 3; i++) begin idle_inputs(); req_accept = (i == 1); step(); end

        // R4 and R11: retry pulses, some refused, index wraps
        cur_req = "R4";
        for (int i = 0; i < 40; i++) begin
            idle_inputs(); req_retry = (i % 2 == 0); req_accept = (i % 4 == 0);
            if (i > 20) cur_req = "R11";
            step();
        end
        for (int i = 0; i < 40; i++) begin
            idle_inputs(); req_retry = 1; req_accept = 1; step();
        end

        // R5: retry while nothing held
        cur_req = "R5";
        for (int i = 0; i < 3; i++) begin idle_inputs(); req_retry = 1; req_accept = 1; step(); end

        // R10: locked load sets link; clear drops it
        cur_req = "R10";
        idle_inputs(); ll_valid = 1; ll_addr = 32'hCAFE_0040; step();
        run_idle(1);

        // R6: uncacheable conditional
        cur_req = "R6";
        idle_inputs(); set_push(1, 1); req_accept = 1; step();
        for (int i = 0; i < 2; i++) begin idle_inputs(); req_accept = 1; step(); end

        // R7: linked conditional, refused, link cleared while held
        cur_req = "R7";
        idle_inputs(); set_push(1, 0); step();
        idle_inputs(); step();
        idle_inputs(); link_clear = 1; step();
        idle_inputs(); req_retry = 1; req_accept = 1; step();
        run_idle(2);

        // R8: conditional with link clear fails at once
        cur_req = "R8";
        idle_inputs(); set_push(1, 0); step();
        run_idle(3);

        // R10: set wins over clear
        cur_req = "R10";
        idle_inputs(); ll_valid = 1; link_clear = 1; ll_addr = 32'h0BAD_0080; step();
        idle_inputs(); link_clear = 1; step();
        run_idle(1);

        // R9: matching stall releases replay; mismatched does not
        cur_req = "R9";
        idle_inputs(); stall_set = 1; stall_seq = SEQ_W'(next_seq); stall_ld_idx = 5'd7; step();
        idle_inputs(); set_push(0, 0); req_accept = 1; step();
        for (int i = 0; i < 2; i++) begin idle_inputs(); req_accept = 1; step(); end
        idle_inputs(); stall_set = 1; stall_seq = 16'hFFF0; stall_ld_idx = 5'd3; step();
        idle_inputs(); set_push(0, 0); req_accept = 1; step();
        for (int i = 0; i < 2; i++) begin idle_inputs(); req_accept = 1; step(); end

        // mixed traffic
        cur_req = "R2";
        for (int i = 0; i < 600; i++) begin
            idle_inputs();
            rnd_next();
            if (lfsr[0] | lfsr[1]) set_push(lfsr[2] & lfsr[3], lfsr[4] & lfsr[5]);
            req_accept = lfsr[6] | lfsr[7];
            req_retry  = lfsr[8];
            ll_valid   = lfsr[9] & lfsr[10];
            ll_addr    = {16'h00AA, lfsr[31:16]};
            link_clear = lfsr[11] & lfsr[12] & lfsr[13];
            if (lfsr[14] & lfsr[15] & (mq.size() > 0)) begin
                stall_set = 1; stall_seq = SEQ_W'(mq[mq.size()-1].s); stall_ld_idx = lfsr[20:16];
            end
            step();
        end
        for (int i = 0; i < 60; i++) begin idle_inputs(); req_retry = 1; req_accept = 1; step(); end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule